// File: doc/BRIEF.md
# Dual-Width Shift and Rotate Execution Unit

This unit is the shift and rotate stage of an accumulator CPU whose data path runs at 8 or 16 bits. It has four operations: shift left, logical shift right, rotate left through carry and rotate right through carry. Each operation works on the accumulator or on an operand in memory. The unit returns the result together with new zero, negative and carry flags. A width flag, sampled when the operation starts, chooses the 8-bit or 16-bit form.

A one-cycle `start` pulse hands over the operation. With it come the operand source, a 24-bit effective address, the current accumulator and the incoming carry. An accumulator operation spends one internal cycle, then pulses `done` and `acc_we` with the new accumulator.

A memory operation runs a read-modify-write sequence on a byte-wide bus:
- It reads the operand low byte first.
- It spends one idle computation cycle with no transfer.
- It writes the result back to the same location. A 16-bit result is written high byte first.

The flags change only in the cycle that `done` is high.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 shifts left with a zero into bit 0. Carry out is the top bit of the active width (bit 7 when `narrow`=1, bit 15 when `narrow`=0).
- R2: Operation code 1 shifts right with a zero into the top bit of the active width. Carry out is bit 0, and the negative flag is always 0.
- R3: Operation code 2 rotates left. The incoming carry goes into bit 0, and carry out is the top bit of the active width.
- R4: Operation code 3 rotates right. The incoming carry goes into the top bit of the active width (bit 7 or bit 15), and carry out is bit 0.
- R5: Zero is 1 exactly when the result, truncated to the active width, is 0. For operations 0, 2 and 3, negative equals the top bit of the active-width result.
- R6: In 8-bit accumulator mode, `acc_out[15:8]` equals `acc_in[15:8]` as it was at start.
- R7: For an accumulator operation (`use_mem`=0), `done` and `acc_we` are high for one cycle, in the second cycle after the start edge. No bus transfer occurs during the operation.
- R8: An 8-bit memory operation reads at the address in cycle 1 after start and performs no transfer in cycle 2. In cycle 3 it writes the result to the same address, and `done` follows in cycle 4. `acc_we` stays 0.
- R9: A 16-bit memory operation reads the low byte at the address and then the high byte at address+1. The increment wraps modulo 2^24.
- R10: A 16-bit memory operation has one idle cycle after the reads. It then writes the high byte to address+1, then the low byte to the address, and `done` follows in cycle 6.
- R11: A `start` that arrives while `busy` is 1 is ignored. The running operation finishes unchanged, and no extra `done` or `acc_we` follows.
- R12: A synchronous reset returns the unit to idle with `busy`, `done`, `acc_we`, `bus_rd` and `bus_wr` all 0, even in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| op | input | 2 | 0 shift left, 1 shift right, 2 rotate left, 3 rotate right |
| use_mem | input | 1 | 1 selects the memory operand, 0 the accumulator |
| narrow | input | 1 | 1 selects 8-bit width, 0 selects 16-bit |
| addr_in | input | 24 | Effective address of the memory operand |
| acc_in | input | 16 | Current accumulator |
| c_in | input | 1 | Incoming carry flag |
| bus_rdata | input | 8 | Read data, valid in the cycle `bus_rd` is high |
| bus_addr | output | 24 | Bus address (registered) |
| bus_rd | output | 1 | Read strobe (registered) |
| bus_wr | output | 1 | Write strobe (registered) |
| bus_wdata | output | 8 | Write data (registered) |
| acc_out | output | 16 | New accumulator value |
| acc_we | output | 1 | One-cycle accumulator write enable |
| flag_c | output | 1 | Carry flag, updated with `done` |
| flag_z | output | 1 | Zero flag, updated with `done` |
| flag_n | output | 1 | Negative flag, updated with `done` |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | High while an operation is in progress |

## Verification
The bench counts falling-edge samples from the start edge, and the count at which each result is due depends on the operation form:
- An accumulator operation has its result, flags and `done` at the second sample.
- An 8-bit memory operation has its read at sample 1, the idle cycle at sample 2, its write at sample 3 and `done` at sample 4.
- A 16-bit memory operation has two reads, one idle cycle and two writes, with `done` at sample 6.

Every sample between start and `done` is recorded and compared against that schedule, so a transfer that is early, late, extra or misordered is caught, as well as a wrong value. Results and flags are read only at the `done` sample, and the quiet cycles after an ignored start are also sampled.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [1:0] {
    SR_ASL = 2'd0,
    SR_LSR = 2'd1,
    SR_ROL = 2'd2,
    SR_ROR = 2'd3
  } sr_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACC,
    ST_RD_LO,
    ST_RD_HI,
    ST_CALC,
    ST_WR_HI,
    ST_WR_LO
  } sr_state_e;

endpackage

// File: rtl/shrot_alu.sv
module shrot_alu
  import shrot_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  sr_op_e                op,
  input  logic                  narrow,
  input  logic [2*BYTE_W-1:0]   opnd,
  input  logic                  cin,
  output logic [2*BYTE_W-1:0]   res,
  output logic                  c_out,
  output logic                  z_out,
  output logic                  n_out
);

  localparam int WORD_W = 2 * BYTE_W;

  logic [1:0] lane_cy;
  logic [1:0] lane_zr;
  logic [1:0] lane_tp;

  // lane 0 is the narrow datapath, lane 1 the wide one
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = BYTE_W * (g + 1);
    logic [LW-1:0] src;
    logic [LW-1:0] dst;
    logic          cy;

    assign src = opnd[LW-1:0];

    always_comb begin
      unique case (op)
        SR_ASL: begin dst = {src[LW-2:0], 1'b0}; cy = src[LW-1]; end
        SR_LSR: begin dst = {1'b0, src[LW-1:1]}; cy = src[0];    end
        SR_ROL: begin dst = {src[LW-2:0], cin};  cy = src[LW-1]; end
        default: begin dst = {cin, src[LW-1:1]}; cy = src[0];    end
      endcase
    end

    assign lane_cy[g] = cy;
    assign lane_zr[g] = (dst == '0);
    assign lane_tp[g] = dst[LW-1];
  end

  always_comb begin
    if (narrow) begin
      res   = {opnd[WORD_W-1:BYTE_W], g_lane[0].dst};
      c_out = lane_cy[0];
      z_out = lane_zr[0];
      n_out = (op == SR_LSR) ? 1'b0 : lane_tp[0];
    end else begin
      res   = g_lane[1].dst;
      c_out = lane_cy[1];
      z_out = lane_zr[1];
      n_out = (op == SR_LSR) ? 1'b0 : lane_tp[1];
    end
  end

endmodule

// File: rtl/shrot_seq.sv
module shrot_seq
  import shrot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic                  use_mem,
  input  logic                  narrow,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [2*BYTE_W-1:0]   acc_in,
  input  logic                  c_in,
  input  logic [BYTE_W-1:0]     bus_rdata,
  // towards the datapath
  output sr_op_e                op_q,
  output logic                  narrow_q,
  output logic [2*BYTE_W-1:0]   opnd_q,
  output logic                  cin_q,
  input  logic [2*BYTE_W-1:0]   alu_res,
  input  logic                  alu_c,
  input  logic                  alu_z,
  input  logic                  alu_n,
  // outward
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [BYTE_W-1:0]     bus_wdata,
  output logic [2*BYTE_W-1:0]   acc_out,
  output logic                  acc_we,
  output logic                  flag_c,
  output logic                  flag_z,
  output logic                  flag_n,
  output logic                  done,
  output logic                  busy
);

  localparam int WORD_W = 2 * BYTE_W;

  sr_state_e         state;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_nxt;

  assign base_nxt = base_q + ADDR_W'(1);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= SR_ASL;
      narrow_q  <= 1'b0;
      opnd_q    <= '0;
      cin_q     <= 1'b0;
      base_q    <= '0;
      bus_addr  <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_wdata <= '0;
      acc_out   <= '0;
      acc_we    <= 1'b0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      flag_n    <= 1'b0;
      done      <= 1'b0;
    end else begin
      done   <= 1'b0;
      acc_we <= 1'b0;
      bus_rd <= 1'b0;
      bus_wr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q     <= sr_op_e'(op);
            narrow_q <= narrow;
            opnd_q   <= acc_in;
            cin_q    <= c_in;
            base_q   <= addr_in;
            if (use_mem) begin
              state    <= ST_RD_LO;
              bus_rd   <= 1'b1;
              bus_addr <= addr_in;
            end else begin
              state <= ST_ACC;
            end
          end
        end
        ST_ACC: begin
          acc_out <= alu_res;
          acc_we  <= 1'b1;
          flag_c  <= alu_c;
          flag_z  <= alu_z;
          flag_n  <= alu_n;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
        ST_RD_LO: begin
          opnd_q[BYTE_W-1:0] <= bus_rdata;
          if (narrow_q) begin
            state <= ST_CALC;
          end else begin
            state    <= ST_RD_HI;
            bus_rd   <= 1'b1;
            bus_addr <= base_nxt;
          end
        end
        ST_RD_HI: begin
          opnd_q[WORD_W-1:BYTE_W] <= bus_rdata;
          state <= ST_CALC;
        end
        ST_CALC: begin
          bus_wr <= 1'b1;
          if (narrow_q) begin
            state     <= ST_WR_LO;
            bus_addr  <= base_q;
            bus_wdata <= alu_res[BYTE_W-1:0];
          end else begin
            state     <= ST_WR_HI;
            bus_addr  <= base_nxt;
            bus_wdata <= alu_res[WORD_W-1:BYTE_W];
          end
        end
        ST_WR_HI: begin
          state     <= ST_WR_LO;
          bus_wr    <= 1'b1;
          bus_addr  <= base_q;
          bus_wdata <= alu_res[BYTE_W-1:0];
        end
        ST_WR_LO: begin
          flag_c <= alu_c;
          flag_z <= alu_z;
          flag_n <= alu_n;
          done   <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic                  use_mem,
  input  logic                  narrow,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic [2*BYTE_W-1:0]   acc_in,
  input  logic                  c_in,
  input  logic [BYTE_W-1:0]     bus_rdata,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic                  bus_rd,
  output logic                  bus_wr,
  output logic [BYTE_W-1:0]     bus_wdata,
  output logic [2*BYTE_W-1:0]   acc_out,
  output logic                  acc_we,
  output logic                  flag_c,
  output logic                  flag_z,
  output logic                  flag_n,
  output logic                  done,
  output logic                  busy
);

  localparam int WORD_W = 2 * BYTE_W;

  sr_op_e              op_q;
  logic                narrow_q;
  logic [WORD_W-1:0]   opnd_q;
  logic                cin_q;
  logic [WORD_W-1:0]   alu_res;
  logic                alu_c;
  logic                alu_z;
  logic                alu_n;

  shrot_alu #(.BYTE_W(BYTE_W)) i_alu (
    .op     (op_q),
    .narrow (narrow_q),
    .opnd   (opnd_q),
    .cin    (cin_q),
    .res    (alu_res),
    .c_out  (alu_c),
    .z_out  (alu_z),
    .n_out  (alu_n)
  );

  shrot_seq #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .op        (op),
    .use_mem   (use_mem),
    .narrow    (narrow),
    .addr_in   (addr_in),
    .acc_in    (acc_in),
    .c_in      (c_in),
    .bus_rdata (bus_rdata),
    .op_q      (op_q),
    .narrow_q  (narrow_q),
    .opnd_q    (opnd_q),
    .cin_q     (cin_q),
    .alu_res   (alu_res),
    .alu_c     (alu_c),
    .alu_z     (alu_z),
    .alu_n     (alu_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .acc_out   (acc_out),
    .acc_we    (acc_we),
    .flag_c    (flag_c),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .done      (done),
    .busy      (busy)
  );

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              acc_we,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr
);

  // R8: a cycle never reads and writes at once
  p_rdwr_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));

  // R8: the read phase is followed by a cycle with no write
  p_calc_gap_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rd) |-> !bus_wr);

  // R9: back-to-back reads step the address up by one
  p_rd_ascend_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && $past(bus_rd)) |-> (bus_addr == $past(bus_addr) + ADDR_W'(1)));

  // R10: back-to-back writes step the address down by one
  p_wr_descend_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && $past(bus_wr)) |-> (bus_addr == $past(bus_addr) - ADDR_W'(1)));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: an accumulator update carries no bus transfer
  p_acc_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
    acc_we |-> (!bus_rd && !bus_wr && done));

  // R8: the first cycle after idle is never a write
  p_no_early_wr_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !bus_wr);

endmodule

bind shrot_unit shrot_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .acc_we   (acc_we),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr)
);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        use_mem = 1'b0;
  logic        narrow = 1'b0;
  logic [23:0] addr_in = '0;
  logic [15:0] acc_in = '0;
  logic        c_in = 1'b0;
  logic [7:0]  bus_rdata;
  logic [23:0] bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [15:0] acc_out;
  logic        acc_we, flag_c, flag_z, flag_n, done, busy;

  always #2.5 clk = ~clk;

  shrot_unit i_shrot_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .use_mem(use_mem),
    .narrow(narrow), .addr_in(addr_in), .acc_in(acc_in), .c_in(c_in),
    .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .acc_out(acc_out),
    .acc_we(acc_we), .flag_c(flag_c), .flag_z(flag_z), .flag_n(flag_n),
    .done(done), .busy(busy)
  );

  // memory model: two bytes at m_a and m_a+1
  logic [23:0] m_a = '0;
  logic [23:0] m_a1;
  logic [7:0]  m_lo = '0, m_hi = '0;
  assign m_a1 = m_a + 24'd1;
  always_comb bus_rdata = (bus_addr == m_a) ? m_lo : (bus_addr == m_a1) ? m_hi : 8'hEE;

  int total = 0;
  int bad = 0;

  // per-sample trace, index = samples after start edge
  logic        tr_rd [16];
  logic        tr_wr [16];
  logic [23:0] tr_ad [16];
  logic [7:0]  tr_wd [16];
  logic        tr_we [16];
  int          lat;

  // {op, narrow, acc, cin, exp_acc, c, z, n}
  localparam logic [38:0] VEC [12] = '{
    {2'd0, 1'b1, 16'h12C5, 1'b0, 16'h128A, 1'b1, 1'b0, 1'b1},
    {2'd0, 1'b0, 16'h8001, 1'b0, 16'h0002, 1'b1, 1'b0, 1'b0},
    {2'd0, 1'b1, 16'hAB80, 1'b0, 16'hAB00, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 16'h34FF, 1'b1, 16'h347F, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b0, 16'h0001, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b0, 16'h8000, 1'b0, 16'h4000, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b1, 16'hFF40, 1'b1, 16'hFF81, 1'b0, 1'b0, 1'b1},
    {2'd2, 1'b0, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {2'd3, 1'b1, 16'h5501, 1'b1, 16'h5580, 1'b1, 1'b0, 1'b1},
    {2'd3, 1'b0, 16'h0002, 1'b1, 16'h8001, 1'b0, 1'b0, 1'b1},
    {2'd3, 1'b0, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0},
    {2'd2, 1'b0, 16'h4000, 1'b1, 16'h8001, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request; intrude>0 pulses an accumulator start at that sample
  task automatic launch(input logic [1:0] o, input logic nr, input logic mem,
                        input logic [23:0] a, input logic [15:0] acc, input logic ci,
                        input int intrude);
    @(negedge clk);
    op = o; narrow = nr; use_mem = mem; addr_in = a; acc_in = acc; c_in = ci;
    start = 1'b1;
    for (int k = 0; k < 16; k++) begin
      tr_rd[k] = 1'b0; tr_wr[k] = 1'b0; tr_ad[k] = '0; tr_wd[k] = '0; tr_we[k] = 1'b0;
    end
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      tr_rd[lat] = bus_rd; tr_wr[lat] = bus_wr; tr_ad[lat] = bus_addr;
      tr_wd[lat] = bus_wdata; tr_we[lat] = acc_we;
      if (lat == intrude) begin
        start = 1'b1; use_mem = 1'b0; op = 2'd0; acc_in = 16'hFFFF; narrow = 1'b0;
      end else begin
        start = 1'b0;
      end
    end while (!done && lat < 14);
    start = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state
    chk(!busy && !done && !acc_we && !bus_rd && !bus_wr, "R12 reset idle",
        {busy, done, acc_we, bus_rd, bus_wr}, 0);
    rst = 1'b0;

    // table of accumulator vectors: R1..R7
    for (int i = 0; i < 12; i++) begin
      logic [38:0] v;
      v = VEC[i];
      launch(v[38:37], v[36], 1'b0, 24'h0, v[35:20], v[19], 0);
      chk(lat == 2, "R7 acc latency", lat, 2);
      chk(acc_we, "R7 acc_we", acc_we, 1);
      chk(!tr_rd[1] && !tr_wr[1] && !tr_rd[2] && !tr_wr[2], "R7 no bus", {tr_rd[1], tr_wr[1]}, 0);
      chk(acc_out == v[18:3], "R1 R2 R3 R4 R6 acc result", acc_out, v[18:3]);
      chk(flag_c == v[2], "R1 R2 R3 R4 carry", flag_c, v[2]);
      chk(flag_z == v[1], "R5 zero", flag_z, v[1]);
      chk(flag_n == v[0], "R5 R2 negative", flag_n, v[0]);
    end

    // R8: 8-bit memory shift left at 0x012345, byte 0x41 -> 0x82
    m_a = 24'h012345; m_lo = 8'h41; m_hi = 8'h00;
    launch(2'd0, 1'b1, 1'b1, 24'h012345, 16'hBEEF, 1'b0, 0);
    chk(lat == 4, "R8 mem8 latency", lat, 4);
    chk(tr_rd[1] && !tr_wr[1] && tr_ad[1] == 24'h012345, "R8 read", tr_ad[1], 24'h012345);
    chk(!tr_rd[2] && !tr_wr[2], "R8 idle cycle", {tr_rd[2], tr_wr[2]}, 0);
    chk(tr_wr[3] && tr_ad[3] == 24'h012345 && tr_wd[3] == 8'h82, "R8 write", {tr_ad[3], tr_wd[3]}, {24'h012345, 8'h82});
    chk(!tr_we[4] && !acc_we, "R8 no acc write", acc_we, 0);
    chk({flag_c, flag_z, flag_n} == 3'b001, "R1 R5 mem8 flags", {flag_c, flag_z, flag_n}, 3'b001);

    // R10: 16-bit rotate right at 0x00F0F0, 0x8003 cin0 -> 0x4001, c1
    m_a = 24'h00F0F0; m_lo = 8'h03; m_hi = 8'h80;
    launch(2'd3, 1'b0, 1'b1, 24'h00F0F0, 16'h0000, 1'b0, 0);
    chk(lat == 6, "R10 mem16 latency", lat, 6);
    chk(tr_rd[1] && tr_ad[1] == 24'h00F0F0, "R9 read low", tr_ad[1], 24'h00F0F0);
    chk(tr_rd[2] && tr_ad[2] == 24'h00F0F1, "R9 read high", tr_ad[2], 24'h00F0F1);
    chk(!tr_rd[3] && !tr_wr[3], "R10 idle cycle", {tr_rd[3], tr_wr[3]}, 0);
    chk(tr_wr[4] && tr_ad[4] == 24'h00F0F1 && tr_wd[4] == 8'h40, "R10 write high first", {tr_ad[4], tr_wd[4]}, {24'h00F0F1, 8'h40});
    chk(tr_wr[5] && tr_ad[5] == 24'h00F0F0 && tr_wd[5] == 8'h01, "R10 write low second", {tr_ad[5], tr_wd[5]}, {24'h00F0F0, 8'h01});
    chk({flag_c, flag_z, flag_n} == 3'b100, "R4 mem16 flags", {flag_c, flag_z, flag_n}, 3'b100);

    // R9: wrap at top of address space, LSR 0x0100 -> 0x0080
    m_a = 24'hFFFFFF; m_lo = 8'h00; m_hi = 8'h01;
    launch(2'd1, 1'b0, 1'b1, 24'hFFFFFF, 16'h0000, 1'b1, 0);
    chk(tr_ad[2] == 24'h000000 && tr_rd[2], "R9 wrapped read", tr_ad[2], 24'h000000);
    chk(tr_ad[4] == 24'h000000 && tr_wd[4] == 8'h00, "R10 wrapped write high", {tr_ad[4], tr_wd[4]}, {24'h000000, 8'h00});
    chk(tr_ad[5] == 24'hFFFFFF && tr_wd[5] == 8'h80, "R10 write low", {tr_ad[5], tr_wd[5]}, {24'hFFFFFF, 8'h80});
    chk({flag_c, flag_z, flag_n} == 3'b000, "R2 mem16 flags", {flag_c, flag_z, flag_n}, 3'b000);

    // R11: start while busy is ignored
    m_a = 24'h000100; m_lo = 8'h01; m_hi = 8'h00;
    launch(2'd2, 1'b0, 1'b1, 24'h000100, 16'h0000, 1'b1, 2);
    chk(lat == 6, "R11 latency kept", lat, 6);
    chk(tr_wd[4] == 8'h00 && tr_wd[5] == 8'h03, "R11 result kept", {tr_wd[4], tr_wd[5]}, 16'h0003);
    begin
      int extra;
      extra = 0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (done || acc_we || busy) extra++;
      end
      chk(extra == 0, "R11 no extra completion", extra, 0);
    end

    // R12: reset in the middle of a memory operation
    @(negedge clk);
    op = 2'd0; narrow = 1'b0; use_mem = 1'b1; addr_in = 24'h000100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_rd && !bus_wr && !done, "R12 mid-op reset", {busy, bus_rd, bus_wr, done}, 0);
    rst = 1'b0;
    launch(2'd0, 1'b1, 1'b0, 24'h0, 16'h0101, 1'b0, 0);
    chk(lat == 2 && acc_out == 16'h0102, "R12 works after reset", acc_out, 16'h0102);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule